// File: doc/BRIEF.md
# Bus-Attached Serial Port with Sticky Receive Flag

This block is a byte-wide serial port for a small processor I/O bus. A write to the data port hands a byte to the transmitter, which drives it onto `txd` as an asynchronous frame. A receiver watches `rxd`, rebuilds incoming bytes and holds the newest one in a data register. The block runs on the system clock. The bus clock arrives as a one-cycle enable, `bus_ce`.

The receive-ready indication does not pulse. It stays set until software reads the data port. A status read returns the ready, busy, overrun and framing-error bits and clears none of them. A write does not start the serializer at once. The request first walks through a short shift-register delay that advances on `bus_ce`. The receiver needs no setting to accept senders that use one or two stop bits.

The bit rate comes from the parameters `CLK_HZ` and `BAUD`. The default rate is 38400 baud, and 9600 baud is equally valid. One bit lasts `(CLK_HZ/(BAUD*16))*16` system clocks.

Top module: `bus_uart_port`

## Requirements
- R1: Each transmitted frame has a low start bit, 8 data bits sent least significant bit first, and `NSTOP` high stop bits (default 1). Each bit lasts `(CLK_HZ/(BAUD*16))*16` clocks. `txd` is high whenever no frame is being sent, including after reset.
- R2: After a write is accepted, `txd` stays high while the next `TX_DLY` (default 3) `bus_ce` pulses occur. It falls at the clock edge of the pulse after those.
- R3: A data write is accepted only when status bit1 (busy) is clear. Busy covers the delay and the whole frame. A write while busy has no effect: the frame carries the earlier byte and no second frame follows.
- R4: A received byte, taken least significant bit first, is stored in the data register. Status bit0 (ready) is then set and stays set until a data read.
- R5: A data read (`data_rd`) makes `rd_data` show the stored byte on the following cycle and clears status bits 0, 2 and 3. A status read (`stat_rd`) makes `rd_data` show `{4'b0, ferr, ovr, busy, rdy}` on the following cycle and clears nothing.
- R6: Frames with one or two stop bits are both received correctly, including when they arrive back to back with no idle time between them.
- R7: A byte that completes while ready is still set overwrites the data register and sets status bit2 (overrun).
- R8: A frame whose stop bit is sampled low is discarded. Ready is not set, the data register keeps its old value, and status bit3 (framing error) is set.
- R9: A low pulse on `rxd` that is back high at the middle of the start bit is ignored. No ready or error bit is set, and a following valid frame is received normally.
- R10: After reset, `rd_data` is 0, all status bits are 0 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ce | input | 1 | One-cycle enable marking each bus clock; advances the transmit delay line |
| data_rd | input | 1 | Data port read strobe, one cycle |
| data_wr | input | 1 | Data port write strobe, one cycle |
| stat_rd | input | 1 | Status port read strobe, one cycle |
| wr_data | input | 8 | Byte to transmit, taken with `data_wr` |
| rd_data | output | 8 | Registered read result, valid the cycle after a read strobe |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |

## Verification
The assertions check these rules on every cycle:
- the line is high while the transmitter is idle;
- a frame only starts on a bus enable;
- a write while busy leaves the held byte unchanged;
- a data read clears ready, and a status read does not;
- overrun only rises while ready is set;
- a framing error never comes with a new ready.

Only the bench scenarios can show the rest: the serial bit order and bit timing on both lines, the exact count of bus enables before the start bit, and the acceptance of mixed stop-bit lengths back to back. The same holds for the rejection of short start glitches and the values returned on `rd_data` after overrun and framing errors.

// File: rtl/uart_bus_pkg.sv
package uart_bus_pkg;
  localparam int ST_RDY  = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_FERR = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV = 81
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_bus_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd_s,
  output logic          done,
  output logic          frame_err,
  output logic [DW-1:0] data
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

  rx_state_t     st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      data      <= '0;
      done      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      done      <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        RX_IDLE: begin
          tcnt <= '0;
          if (!rxd_s) st <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt == CW'(HALF - 1)) begin
            tcnt <= '0;
            bcnt <= '0;
            st   <= rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            data <= {rxd_s, data[DW-1:1]};
            if (bcnt == BW'(DW - 1)) st <= RX_STOP;
            else bcnt <= bcnt + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            if (rxd_s) begin
              done <= 1'b1;
              st   <= RX_IDLE;
            end else begin
              frame_err <= 1'b1;
              st        <= RX_HOLD;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_HOLD: if (rxd_s) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int OVS   = 16,
  parameter int DW    = 8,
  parameter int NSTOP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          txd,
  output logic          active
);
  localparam int NB = DW + 1 + NSTOP;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(NB + 1);

  logic [NB-1:0] frame;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame  <= '1;
      tcnt   <= '0;
      bcnt   <= '0;
      txd    <= 1'b1;
      active <= 1'b0;
    end else if (start && !active) begin
      frame  <= {{NSTOP{1'b1}}, din, 1'b0};
      tcnt   <= '0;
      bcnt   <= '0;
      txd    <= 1'b0;
      active <= 1'b1;
    end else if (active && tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt <= '0;
        if (bcnt == BW'(NB - 1)) begin
          active <= 1'b0;
          txd    <= 1'b1;
        end else begin
          bcnt  <= bcnt + 1'b1;
          frame <= {1'b1, frame[NB-1:1]};
          txd   <= frame[1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_launch_delay.sv
module tx_launch_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic arm,
  output logic fire,
  output logic pending
);
  logic             req;
  logic [DEPTH-1:0] line;

  always_ff @(posedge clk) begin
    if (rst)      req <= 1'b0;
    else if (arm) req <= 1'b1;
    else if (ce)  req <= 1'b0;
  end

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     line <= '0;
        else if (ce) line <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)     line <= '0;
        else if (ce) line <= {line[DEPTH-2:0], req};
      end
    end
  endgenerate

  assign fire    = ce & line[DEPTH-1];
  assign pending = req | (|line);
endmodule

// File: rtl/bus_uart_port.sv
module bus_uart_port
  import uart_bus_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 38400,
  parameter int OVS    = 16,
  parameter int NSTOP  = 1,
  parameter int TX_DLY = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_ce,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic       stat_rd,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rxd,
  output logic       txd
);
  localparam int DW  = 8;
  localparam int DIV = CLK_HZ / (BAUD * OVS);

  logic          tick;
  logic [1:0]    rx_sync;
  logic          rx_done, rx_fe;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] tx_hold;
  logic          rdy, ovr, ferr;
  logic          tx_active, dly_busy, busy, fire, accept;
  logic [7:0]    status;

  uart_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rxd};
  end

  uart_rx_core #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_s(rx_sync[1]),
    .done(rx_done), .frame_err(rx_fe), .data(rx_byte)
  );

  assign busy   = tx_active | dly_busy;
  assign accept = data_wr & ~busy;

  tx_launch_delay #(.DEPTH(TX_DLY)) u_dly (
    .clk(clk), .rst(rst), .ce(bus_ce), .arm(accept),
    .fire(fire), .pending(dly_busy)
  );

  uart_tx_core #(.OVS(OVS), .DW(DW), .NSTOP(NSTOP)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .start(fire), .din(tx_hold),
    .txd(txd), .active(tx_active)
  );

  always_ff @(posedge clk) begin
    if (rst)         tx_hold <= '0;
    else if (accept) tx_hold <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rdy     <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      if (rx_done) rx_data <= rx_byte;
      if (rx_done)      rdy <= 1'b1;
      else if (data_rd) rdy <= 1'b0;
      if (rx_done && rdy && !data_rd) ovr <= 1'b1;
      else if (data_rd)               ovr <= 1'b0;
      if (rx_fe)        ferr <= 1'b1;
      else if (data_rd) ferr <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_RDY]  = rdy;
    status[ST_BUSY] = busy;
    status[ST_OVR]  = ovr;
    status[ST_FERR] = ferr;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (data_rd) rd_data <= rx_data;
    else if (stat_rd) rd_data <= status;
  end
endmodule

// File: rtl/bus_uart_port_chk.sv
module bus_uart_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_ce,
  input logic       data_rd,
  input logic       data_wr,
  input logic       stat_rd,
  input logic       txd,
  input logic       tx_active,
  input logic       busy,
  input logic       rdy,
  input logic       ovr,
  input logic       ferr,
  input logic       rx_done,
  input logic [7:0] tx_hold
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> txd); // R1
  AST_START_ON_CE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> $past(bus_ce)); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy) |=> $stable(tx_hold)); // R3
  AST_READ_CLEARS_RDY: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rx_done) |=> !rdy); // R5
  AST_STATUS_KEEPS_RDY: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !data_rd && rdy) |=> rdy); // R5
  AST_OVR_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(rdy)); // R7
  AST_FERR_NO_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr) |-> !$rose(rdy)); // R8
endmodule

bind bus_uart_port bus_uart_port_chk u_chk (
  .clk(clk), .rst(rst), .bus_ce(bus_ce), .data_rd(data_rd),
  .data_wr(data_wr), .stat_rd(stat_rd), .txd(txd),
  .tx_active(tx_active), .busy(busy), .rdy(rdy), .ovr(ovr),
  .ferr(ferr), .rx_done(rx_done), .tx_hold(tx_hold)
);

// File: tb/bus_uart_port_bench.sv
module bus_uart_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD   = 38400;
  localparam int OVS    = 16;
  localparam int CLK_HZ = BAUD * OVS * 4;
  localparam int TX_DLY = 3;
  localparam int NSTOP  = 1;
  localparam int BT     = (CLK_HZ / (BAUD * OVS)) * OVS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_ce = 1'b0;
  logic       data_rd = 1'b0, data_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rxd = 1'b1;
  logic       txd;
  logic [2:0] cecnt = '0;
  int         checks = 0, fails = 0;
  bit         finished = 0;

  bus_uart_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS),
                  .NSTOP(NSTOP), .TX_DLY(TX_DLY)) u_bus_uart_port (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .data_rd(data_rd),
    .data_wr(data_wr), .stat_rd(stat_rd), .wr_data(wr_data),
    .rd_data(rd_data), .rxd(rxd), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cecnt  <= cecnt + 1'b1;
    bus_ce <= (cecnt == 3'd7);
  end

  function automatic logic [7:0] stat_word(bit r, bit b, bit o, bit f);
    return {4'b0, f, o, b, r};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_status(output logic [7:0] v);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; v = rd_data;
  endtask

  task automatic read_data(output logic [7:0] v);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0; v = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      read_status(s);
      if (!s[1]) break;
    end
  endtask

  // mode 0: single write; 1: extra write during delay; 2: extra write mid-frame
  task automatic tx_frame(input logic [7:0] b, input int mode, input logic [7:0] b2);
    int n = 0;
    bit early = 0, quiet = 1, drop = 0;
    logic [7:0] got;
    @(negedge clk); wr_data = b; data_wr = 1'b1;
    @(negedge clk);
    if (mode == 1) begin wr_data = b2; drop = 1; end
    else data_wr = 1'b0;
    forever begin
      if (txd !== 1'b1) early = 1;
      if (bus_ce) n++;
      @(negedge clk);
      if (drop) begin data_wr = 1'b0; drop = 0; end
      if (n == TX_DLY + 1) break;
    end
    check(!early, "R2 txd high during delay", early, 0);
    check(txd === 1'b0, "R2 start bit after delay", txd, 0);
    repeat (BT/2) @(negedge clk);
    check(txd === 1'b0, "R1 start bit low", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BT) @(negedge clk);
      got[i] = txd;
      if (mode == 2 && i == 3) begin
        wr_data = b2; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
        repeat (BT - 1) @(negedge clk);
        i++; got[i] = txd;
      end
    end
    for (int s = 0; s < NSTOP; s++) begin
      repeat (BT) @(negedge clk);
      check(txd === 1'b1, "R1 stop bit high", txd, 1);
    end
    check(got == b, (mode == 0) ? "R1 tx data" : "R3 busy write ignored, data", got, b);
    wait_idle();
    if (mode != 0) begin
      for (int i = 0; i < 2*BT; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) quiet = 0;
      end
      check(quiet, "R3 no second frame", quiet, 1);
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input int nstop, input bit bad_stop);
    @(negedge clk); rxd = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BT) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (BT) @(negedge clk);
    rxd = 1'b1;
    if (nstop == 2) repeat (BT) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b, prev;
    int ns;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 8'h00, "R10 rd_data after reset", rd_data, 0);
    check(txd === 1'b1, "R10 txd after reset", txd, 1);
    read_status(v);
    check(v == 8'h00, "R10 status after reset", v, 0);

    // transmit: directed then random
    tx_frame(8'hA5, 0, 8'h00);
    tx_frame(8'h01, 0, 8'h00);
    tx_frame(8'h3C, 1, 8'hFF);
    tx_frame(8'h80, 2, 8'h55);
    for (int k = 0; k < 4; k++) tx_frame(8'($urandom), 0, 8'h00);

    // busy visible on status during the delay
    @(negedge clk); wr_data = 8'h77; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    read_status(v);
    check(v == stat_word(0, 1, 0, 0), "R3 busy bit during delay", v, stat_word(0,1,0,0));
    wait_idle();
    repeat (BT) @(negedge clk);

    // receive basic, sticky and status read non-clearing
    rx_send(8'h5A, 1, 0);
    repeat (3*BT) @(negedge clk);
    read_status(v);
    check(v == stat_word(1, 0, 0, 0), "R4 ready sticky", v, stat_word(1,0,0,0));
    read_status(v);
    check(v == stat_word(1, 0, 0, 0), "R5 status read keeps ready", v, stat_word(1,0,0,0));
    read_data(v);
    check(v == 8'h5A, "R4 rx data", v, 8'h5A);
    read_status(v);
    check(v == 8'h00, "R5 data read clears ready", v, 0);

    // back-to-back frames, mixed stop lengths
    rx_send(8'hC3, 2, 0);
    fork
      rx_send(8'h96, 1, 0);
      begin
        read_status(v);
        check(v[0] == 1'b1, "R6 ready after 2-stop frame", v, 1);
        read_data(v);
        check(v == 8'hC3, "R6 2-stop data", v, 8'hC3);
      end
    join
    fork
      rx_send(8'h0F, 2, 0);
      begin
        read_data(v);
        check(v == 8'h96, "R6 1-stop data back to back", v, 8'h96);
      end
    join
    repeat (BT) @(negedge clk);
    read_data(v);
    check(v == 8'h0F, "R6 2-stop data after 1-stop", v, 8'h0F);

    // random receive
    for (int k = 0; k < 5; k++) begin
      b = 8'($urandom);
      ns = 1 + int'($urandom % 2);
      rx_send(b, ns, 0);
      repeat (BT/2) @(negedge clk);
      read_data(v);
      check(v == b, "R4 random rx data", v, b);
    end

    // overrun
    rx_send(8'h11, 1, 0);
    rx_send(8'h22, 1, 0);
    repeat (BT/2) @(negedge clk);
    read_status(v);
    check(v == stat_word(1, 0, 1, 0), "R7 overrun status", v, stat_word(1,0,1,0));
    read_data(v);
    check(v == 8'h22, "R7 overwritten data", v, 8'h22);
    read_status(v);
    check(v == 8'h00, "R7 overrun cleared by data read", v, 0);
    prev = 8'h22;

    // framing error
    rx_send(8'hE7, 1, 1);
    repeat (BT) @(negedge clk);
    read_status(v);
    check(v == stat_word(0, 0, 0, 1), "R8 framing error status", v, stat_word(0,0,0,1));
    read_data(v);
    check(v == prev, "R8 data register kept", v, prev);
    read_status(v);
    check(v == 8'h00, "R8 ferr cleared by data read", v, 0);

    // start glitch
    @(negedge clk); rxd = 1'b0;
    repeat (BT/5) @(negedge clk);
    rxd = 1'b1;
    repeat (2*BT) @(negedge clk);
    read_status(v);
    check(v == 8'h00, "R9 glitch ignored", v, 0);
    rx_send(8'h6B, 1, 0);
    repeat (BT/2) @(negedge clk);
    read_data(v);
    check(v == 8'h6B, "R9 frame after glitch", v, 8'h6B);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule